// File: doc/BRIEF.md
# NAND Page-Program Command Sequencer

This block is the device-side command front end of a NAND flash memory, limited to the page-program path. The host presents one bus cycle at a time, tagged as a command, an address byte, a write byte or a read strobe. A program setup command is followed by five address cycles. The block then loads write bytes into a page-wide data register, moving its column pointer either one step per byte or to a new column given by a random-input command. A confirm command starts a timed internal program pass, during which the ready/busy output is low.

The array is a small behavioural store. A program pass ANDs the loaded bytes into the addressed page, so bits only move from 1 to 0. Columns that were not loaded in the sequence are left alone. Each page allows a fixed number of program passes before its block must be erased. While busy, the sequencer reacts only to status and reset commands. After a pass it stays in status mode, so read strobes return the status byte. A small page-read command and a block-erase command exist so that the array contents can be observed and the per-page pass counts can be cleared.

Top module: `nand_pgm_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `ready_busy` is 1 and `rd_valid` is 0.
- R2: Bus kind encoding: 0 = command, 1 = address, 2 = write byte, 3 = read strobe. A program is command 80h, then five address cycles (column low, column high, three row bytes, with the page taken from the low bits of the first row byte), then write bytes, then command 10h. A 10h that arrives before any write byte is ignored: no busy phase, and loading continues.
- R3: Write bytes go to consecutive columns, starting at the column from the address cycles. Columns not written in the sequence keep their array value.
- R4: During loading, command 85h followed by two address cycles (column low, column high) moves the load pointer to that column. This may repeat any number of times, and a later byte to the same column replaces an earlier one.
- R5: A program pass stores the bitwise AND of the old array byte and the loaded byte.
- R6: `ready_busy` is low for exactly `T_PROG` cycles, starting the cycle after an accepted 10h. It then returns high and status bit 6 reads 1.
- R7: A page accepts at most `LIMIT` (4) program passes. A further 10h on that page starts no pass and changes no data, and the status reads C1h. Erase (60h, three row cycles, D0h) fills the addressed block with FFh and clears its pages' counts.
- R8: While busy, every command except 70h and FFh has no effect. Address and write cycles are also ignored.
- R9: Status byte: bit 7 = 1, bit 6 = ready, bit 0 = rejected pass, all other bits 0. After 10h, 70h or an erase, each read strobe returns the status byte until another valid command is accepted.
- R10: Command FFh aborts loading or a program pass. `ready_busy` is high on the next cycle, and an aborted pass writes nothing, even when FFh arrives in the last busy cycle.
- R11: Read (00h, five address cycles, 30h) copies the page into the data register. Each read strobe then returns the byte at the next column, one cycle later with `rd_valid` high, and FFh past the page end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_kind | input | 2 | Cycle kind: command, address, write byte, read strobe |
| bus_data | input | 8 | Command code, address byte or write byte |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous read strobe |
| rd_data | output | 8 | Status byte or page byte |
| ready_busy | output | 1 | 1 when ready, 0 during a program pass |

## Verification
A reset command and the completion of a program pass can fall in the same cycle. In that case the abort must win, and the array write-back must not happen. The bench provokes this by timing FFh to be sampled on exactly the edge where the busy timer expires. It then judges the result through the ports: `ready_busy` must be high one cycle later, and a page read must show the column still at FFh. A second abort in mid-pass checks the same outcome away from that edge.

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq #(
  parameter int PAGE_BYTES = 2112,
  parameter int PAGES      = 2,
  parameter int PPB        = 2,
  parameter int LIMIT      = 4,
  parameter int T_PROG     = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic [1:0] bus_kind,
  input  logic [7:0] bus_data,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       ready_busy
);
  localparam int CW  = $clog2(PAGE_BYTES);
  localparam int PW  = $clog2(PAGES);
  localparam int TW  = $clog2(T_PROG + 1);
  localparam int NW  = $clog2(LIMIT + 1);
  localparam logic [1:0] K_CMD = 2'd0, K_ADR = 2'd1, K_WR = 2'd2, K_RD = 2'd3;
  localparam logic [7:0] C_PROG = 8'h80, C_RND = 8'h85, C_CONF = 8'h10, C_STAT = 8'h70,
                         C_RST = 8'hFF, C_READ = 8'h00, C_RCONF = 8'h30, C_ERS = 8'h60,
                         C_ECONF = 8'hD0;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOAD, S_RCOL, S_PROG, S_RADDR, S_EADDR} st_t;

  st_t           st;
  logic [2:0]    ac;
  logic [CW-1:0] col, rd_col;
  logic [PW-1:0] pg;
  logic [TW-1:0] tmr;
  logic          got, smode, fail;
  logic [NW-1:0] cnt [PAGES];
  logic [7:0]    arr [PAGES][PAGE_BYTES];
  logic [7:0]    preg [PAGE_BYTES];
  logic          mask [PAGE_BYTES];

  wire busy     = (st == S_PROG);
  wire cmd_v    = bus_valid && bus_kind == K_CMD;
  wire rst_cmd  = cmd_v && bus_data == C_RST;
  wire done     = busy && tmr == TW'(1) && !rst_cmd;
  wire setup    = cmd_v && bus_data == C_PROG && !busy;
  wire wr_byte  = bus_valid && bus_kind == K_WR && st == S_LOAD && col < CW'(PAGE_BYTES);
  wire ld_page  = cmd_v && bus_data == C_RCONF && st == S_RADDR && ac == 3'd5;
  wire erase_go = cmd_v && bus_data == C_ECONF && st == S_EADDR && ac == 3'd3;
  wire [7:0] status = {1'b1, !busy, 5'b0, fail};

  assign ready_busy = !busy;

  always_ff @(posedge clk) begin
    if (setup)
      for (int c = 0; c < PAGE_BYTES; c++) mask[c] <= 1'b0;
    if (wr_byte) begin
      preg[col] <= bus_data;
      mask[col] <= 1'b1;
    end
    if (ld_page)
      for (int c = 0; c < PAGE_BYTES; c++) preg[c] <= arr[pg][c];
    if (done)
      for (int c = 0; c < PAGE_BYTES; c++)
        if (mask[c]) arr[pg][c] <= arr[pg][c] & preg[c];
    if (erase_go)
      for (int p = 0; p < PAGES; p++)
        if (p / PPB == int'(pg) / PPB)
          for (int c = 0; c < PAGE_BYTES; c++) arr[p][c] <= 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ac <= '0; col <= '0; rd_col <= '0; pg <= '0; tmr <= '0;
      got <= 1'b0; smode <= 1'b0; fail <= 1'b0; rd_valid <= 1'b0; rd_data <= 8'h00;
      for (int p = 0; p < PAGES; p++) cnt[p] <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (busy) tmr <= tmr - TW'(1);
      if (done) st <= S_IDLE;
      if (bus_valid) begin
        if (bus_kind == K_CMD) begin
          if (bus_data == C_RST) begin
            st <= S_IDLE; smode <= 1'b0; fail <= 1'b0;
          end else if (bus_data == C_STAT) begin
            smode <= 1'b1;
          end else if (!busy) begin
            case (bus_data)
              C_PROG:  begin st <= S_ADDR; ac <= '0; got <= 1'b0; smode <= 1'b0; end
              C_RND:   if (st == S_LOAD) begin st <= S_RCOL; ac <= '0; end
              C_CONF:  if (st == S_LOAD && got) begin
                         smode <= 1'b1;
                         if (cnt[pg] < NW'(LIMIT)) begin
                           st <= S_PROG; tmr <= TW'(T_PROG); fail <= 1'b0;
                           cnt[pg] <= cnt[pg] + NW'(1);
                         end else begin
                           st <= S_IDLE; fail <= 1'b1;
                         end
                       end
              C_READ:  begin st <= S_RADDR; ac <= '0; smode <= 1'b0; end
              C_RCONF: if (ld_page) begin st <= S_IDLE; rd_col <= col; smode <= 1'b0; end
              C_ERS:   begin st <= S_EADDR; ac <= '0; smode <= 1'b0; end
              C_ECONF: if (erase_go) begin
                         for (int p = 0; p < PAGES; p++)
                           if (p / PPB == int'(pg) / PPB) cnt[p] <= '0;
                         st <= S_IDLE; smode <= 1'b1; fail <= 1'b0;
                       end
              default: ;
            endcase
          end
        end else if (bus_kind == K_ADR) begin
          case (st)
            S_ADDR, S_RADDR: if (ac < 3'd5) begin
              ac <= ac + 3'd1;
              if (ac == 3'd0) col[7:0] <= bus_data;
              if (ac == 3'd1) col[CW-1:8] <= bus_data[CW-9:0];
              if (ac == 3'd2) pg <= bus_data[PW-1:0];
              if (ac == 3'd4 && st == S_ADDR) st <= S_LOAD;
            end
            S_RCOL: begin
              if (ac == 3'd0) begin col[7:0] <= bus_data; ac <= 3'd1; end
              else begin col[CW-1:8] <= bus_data[CW-9:0]; st <= S_LOAD; end
            end
            S_EADDR: if (ac < 3'd3) begin
              if (ac == 3'd0) pg <= bus_data[PW-1:0];
              ac <= ac + 3'd1;
            end
            default: ;
          endcase
        end else if (bus_kind == K_WR) begin
          if (st == S_LOAD) begin col <= col + CW'(1); got <= 1'b1; end
        end else begin
          rd_valid <= 1'b1;
          if (smode) rd_data <= status;
          else begin
            rd_data <= (rd_col < CW'(PAGE_BYTES)) ? preg[rd_col] : 8'hFF;
            rd_col  <= rd_col + CW'(1);
          end
        end
      end
    end
  end

  assert_noload_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && cmd_v && bus_data == C_CONF && !got) |=> (st == S_LOAD && ready_busy));
  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr == TW'(1) && !rst_cmd) |=> (ready_busy && smode));
  assert_pass_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && cmd_v && bus_data == C_CONF && got) |=>
      ((st == S_PROG) == $past(cnt[pg] < NW'(LIMIT))));
  assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[pg] <= NW'(LIMIT));
  assert_busy_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != TW'(1) && cmd_v && bus_data != C_STAT && bus_data != C_RST) |=> busy);
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (st == S_IDLE && ready_busy));
endmodule

// File: tb/sim_nand_pgm_seq.sv
module sim_nand_pgm_seq;
  localparam int TP = 20;
  logic clk = 1'b0, rst_n = 1'b0, bv = 1'b0;
  logic [1:0] bk = 2'd0;
  logic [7:0] bd = 8'h00;
  logic rdv, rb;
  logic [7:0] rdd;
  int n_run = 0, n_fail = 0;
  logic [7:0] expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  nand_pgm_seq #(.T_PROG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_kind(bk), .bus_data(bd),
    .rd_valid(rdv), .rd_data(rdd), .ready_busy(rb));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rdv) begin
    if (expq.size() == 0) check("R11 unexpected read", rdd, 8'hxx);
    else begin
      logic [7:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(t, rdd, e);
    end
  end

  task automatic bw(logic [1:0] k, logic [7:0] d);
    @(negedge clk); bv = 1'b1; bk = k; bd = d;
  endtask
  task automatic idle();
    @(negedge clk); bv = 1'b0;
  endtask
  task automatic cmd(logic [7:0] d); bw(2'd0, d); endtask
  task automatic adr5(int c, int p);
    bw(2'd1, 8'(c)); bw(2'd1, 8'(c >> 8)); bw(2'd1, 8'(p)); bw(2'd1, 8'h00); bw(2'd1, 8'h00);
  endtask
  task automatic wr(logic [7:0] d); bw(2'd2, d); endtask
  task automatic rd(logic [7:0] e, string tag);
    expq.push_back(e); tagq.push_back(tag); bw(2'd3, 8'h00);
  endtask
  task automatic page_read(int p, int c);
    cmd(8'h00); adr5(c, p); cmd(8'h30);
  endtask
  task automatic erase();
    cmd(8'h60); bw(2'd1, 8'h00); bw(2'd1, 8'h00); bw(2'd1, 8'h00); cmd(8'hD0);
  endtask
  task automatic wait_ready(string tag, bit exact);
    int n = 0;
    while (!rb && n < 1000) begin n++; @(negedge clk); end
    if (exact) check(tag, 8'(n), 8'(TP));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ready in reset", {7'b0, rb}, 8'h01);
    check("R1 no read valid", {7'b0, rdv}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {7'b0, rb}, 8'h01);

    erase(); rd(8'hC0, "R9 status after erase"); idle();

    cmd(8'h80); adr5(0, 0); wr(8'hA5); wr(8'h3C); wr(8'hFF); wr(8'h0F); cmd(8'h10); idle();
    wait_ready("R6 busy length", 1'b1);
    rd(8'hC0, "R9 status after pass"); rd(8'hC0, "R9 status persists");
    page_read(0, 0);
    rd(8'hA5, "R3 col0"); rd(8'h3C, "R3 col1"); rd(8'hFF, "R3 col2");
    rd(8'h0F, "R3 col3"); rd(8'hFF, "R3 unloaded col4"); idle();

    cmd(8'h80); adr5(0, 0); wr(8'h0F); cmd(8'h10); idle(); wait_ready("R6 second pass", 1'b1);
    page_read(0, 0); rd(8'h05, "R5 AND into array"); rd(8'h3C, "R3 col1 kept"); idle();

    cmd(8'h80); adr5(2, 0); cmd(8'h10); idle();
    check("R2 empty confirm ignored", {7'b0, rb}, 8'h01);
    wr(8'hF0); cmd(8'h10); idle(); wait_ready("R2 confirm after data", 1'b1);

    cmd(8'h80); adr5(10, 1); wr(8'h11); wr(8'h22);
    cmd(8'h85); bw(2'd1, 8'd100); bw(2'd1, 8'h00); wr(8'h33);
    cmd(8'h85); bw(2'd1, 8'd11); bw(2'd1, 8'h00); wr(8'h44); wr(8'h55);
    cmd(8'h10); idle(); wait_ready("R6 random pass", 1'b0);
    page_read(1, 10);
    rd(8'h11, "R4 col10"); rd(8'h44, "R4 overwrite col11"); rd(8'h55, "R4 col12");
    rd(8'hFF, "R4 col13 untouched");
    page_read(1, 100); rd(8'h33, "R4 jump col100"); rd(8'hFF, "R4 col101"); idle();

    cmd(8'h80); adr5(200, 1); wr(8'h00); cmd(8'h10);
    cmd(8'h00); cmd(8'h80); bw(2'd1, 8'd10); wr(8'h12); cmd(8'h70);
    rd(8'h80, "R8 status while busy"); idle();
    wait_ready("R8 pass completes", 1'b0);
    rd(8'hC0, "R8 ignored cmds kept status mode");
    page_read(1, 200); rd(8'h00, "R8 pass data");
    page_read(1, 10); rd(8'h11, "R8 busy write ignored"); idle();

    cmd(8'h80); adr5(3, 0); wr(8'h00); cmd(8'h10); idle(); wait_ready("R7 fourth pass", 1'b1);
    cmd(8'h80); adr5(4, 0); wr(8'h00); cmd(8'h10); idle();
    check("R7 fifth pass no busy", {7'b0, rb}, 8'h01);
    rd(8'hC1, "R7 reject status");
    page_read(0, 3); rd(8'h00, "R7 fourth pass data"); rd(8'hFF, "R7 rejected data absent"); idle();

    erase(); rd(8'hC0, "R7 erase status");
    page_read(0, 0); rd(8'hFF, "R7 erased byte");
    cmd(8'h80); adr5(4, 0); wr(8'h5A); cmd(8'h10); idle(); wait_ready("R7 pass after erase", 1'b1);
    page_read(0, 4); rd(8'h5A, "R7 data after erase"); idle();

    cmd(8'h80); adr5(0, 1); wr(8'h00); cmd(8'h10); idle();
    repeat (TP - 2) @(negedge clk);
    cmd(8'hFF); idle();
    check("R10 ready after last-cycle abort", {7'b0, rb}, 8'h01);
    cmd(8'h80); adr5(1, 1); wr(8'h00); cmd(8'h10); idle();
    repeat (5) @(negedge clk);
    cmd(8'hFF); idle();
    check("R10 ready after mid abort", {7'b0, rb}, 8'h01);
    page_read(1, 0); rd(8'hFF, "R10 last-cycle abort wrote nothing");
    rd(8'hFF, "R10 mid abort wrote nothing");
    page_read(1, 2111); rd(8'hFF, "R11 last col"); rd(8'hFF, "R11 past page end"); idle();

    repeat (3) @(negedge clk);
    if (expq.size() != 0) check("R11 missing reads", 8'(expq.size()), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule